// File: doc/BRIEF.md
# Cycle-Period Stretch/Shrink Sequencer

This block steers a speed-characterisation loop. A pattern of `NUM_VEC` vectors is applied again and again. On every run, each vector is given either a slow (safe) clock period or a fast (target) clock period. The sequencer decides which vectors get the fast period. It then takes in one pass/fail verdict per run and moves to its next choice. It stops once it can name the first vector whose shortened cycle breaks the device, or once it has shown that no vector does.

A pulse on `start` picks one of four strategies through `mode_sel`:
- **Single-shift (0):** exactly one vector is fast, and that vector moves forward after each pass.
- **Accumulate (1):** every vector up to the current one is fast, so the fast set grows after each pass.
- **Halving (2):** vectors from 0 up to the midpoint of a shrinking index window are fast.
- **Relax (3):** the first run has every vector fast. Each failing run moves one more vector back to the slow period.

Period selection is a combinational lookup. The pattern runner presents a vector index on `lookup_idx` and reads the period for that vector in the same cycle.

Verdicts enter through a valid/ready stream. A verdict is consumed only on a cycle where `res_valid` and `res_ready` are both high. `res_ready` is high only while a search is active. Before the first start, and after completion, the block applies back-pressure permanently and ignores every verdict. The runner may hold `res_valid` high for as long as it likes.

Top module: `cyc_stretch_seq`

## Requirements
- R1: After reset, `done`, `res_ready` and `no_fail` are 0.
- R2: In the cycle after `start` is high, `res_ready` is 1 and `done` is 0. The start also records `mode_sel` and clears the run position, so the pointer is 0 and the halving window is [0, NUM_VEC]. A start that arrives during an active search restarts it.
- R3: In single-shift mode (`mode_sel`=0), while active, `lookup_period` equals `fast_period` only when `lookup_idx` equals the run pointer. For every other index it equals `slow_period`. Each passing verdict increments the pointer.
- R4: In accumulate mode (`mode_sel`=1), while active, `lookup_period` equals `fast_period` exactly for indices less than or equal to the pointer.
- R5: In halving mode (`mode_sel`=2), while active, an index is fast exactly when it is ≤ mid, where mid = floor((lo+hi)/2). A pass sets lo = mid+1; a fail sets hi = mid.
- R6: In relax mode (`mode_sel`=3), while active, an index is fast exactly when it is ≥ the pointer. The pointer starts at 0, so the first run is entirely fast, and each failing verdict increments the pointer.
- R7: In single-shift and accumulate modes, a failing verdict ends the search with `fail_idx` equal to the pointer. A passing verdict while the pointer is NUM_VEC-1 ends the search with `no_fail`=1.
- R8: In relax mode, a pass ends the search. If the pointer is 0, `no_fail`=1; otherwise `fail_idx` is the pointer minus 1. A fail while the pointer is NUM_VEC-1 ends the search with `fail_idx`=NUM_VEC-1.
- R9: In halving mode, the search ends in the cycle after lo and hi become equal. If they meet at NUM_VEC, `no_fail`=1; otherwise `fail_idx` is that index.
- R10: `done` rises in the cycle after the final verdict is accepted, and at the same moment `res_ready` falls. `done`, `no_fail` and `fail_idx` then hold their values, and any verdict is ignored, until the next `start`.
- R11: Whenever no search is active, `lookup_period` equals `slow_period` for every index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search |
| mode_sel | input | 2 | Strategy: 0 single-shift, 1 accumulate, 2 halving, 3 relax |
| slow_period | input | PER_W | Safe period value |
| fast_period | input | PER_W | Target period value |
| lookup_idx | input | IDX_W | Vector index being queried |
| lookup_period | output | PER_W | Period for `lookup_idx`, same cycle |
| res_valid | input | 1 | Run verdict is present |
| res_pass | input | 1 | Verdict: 1 pass, 0 fail |
| res_ready | output | 1 | Verdict can be accepted (search active) |
| done | output | 1 | Search finished; result valid |
| no_fail | output | 1 | No failing vector was found |
| fail_idx | output | CNT_W | First failing vector index |

## Verification
The hardest situations to reach are the end points of each strategy. Examples are a failure on the very last vector in relax mode and a halving search whose window closes at NUM_VEC. Both need a device that reacts to the periods the block actually hands out.

The bench plays that device. It sweeps every index through the lookup port on every run, and it fails the run only when a chosen culprit vector received the fast period. Moving the culprit to the first index, to the last index, or to no index at all reaches each end point in every mode.

Restarting in the middle of a search, and holding verdicts against back-pressure after completion, are driven directly.

// File: rtl/cyc_stretch_pkg.sv
package cyc_stretch_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_ACCUM  = 2'd1,
    MODE_HALVE  = 2'd2,
    MODE_RELAX  = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/cyc_stretch_fastmap.sv
module cyc_stretch_fastmap
  import cyc_stretch_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int IDX_W   = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  parameter int CNT_W   = $clog2(NUM_VEC + 1)
) (
  input  seq_mode_e        mode,
  input  logic             busy,
  input  logic [CNT_W-1:0] ptr,
  input  logic [CNT_W-1:0] mid,
  input  logic [IDX_W-1:0] idx,
  output logic             fast
);
  logic [CNT_W-1:0] cidx;
  logic             sel;

  assign cidx = CNT_W'(idx);

  always_comb begin
    case (mode)
      MODE_SHIFT: sel = (cidx == ptr);
      MODE_ACCUM: sel = (cidx <= ptr);
      MODE_HALVE: sel = (cidx <= mid);
      default:    sel = (cidx >= ptr);
    endcase
  end

  assign fast = busy & sel;
endmodule

// File: rtl/cyc_stretch_ctrl.sv
module cyc_stretch_ctrl
  import cyc_stretch_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int CNT_W   = $clog2(NUM_VEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  seq_mode_e        mode_in,
  input  logic             res_valid,
  input  logic             res_pass,
  output logic             busy,
  output seq_mode_e        mode_q,
  output logic [CNT_W-1:0] ptr,
  output logic [CNT_W-1:0] mid,
  output logic             done,
  output logic             no_fail,
  output logic [CNT_W-1:0] fail_idx
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NUM_VEC - 1);
  localparam logic [CNT_W-1:0] NV_C   = CNT_W'(NUM_VEC);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [CNT_W-1:0] lo, hi;
  logic [CNT_W-1:0] ptr_n, lo_n, hi_n, fin_idx;
  logic [CNT_W:0]   sum;
  logic             fin, fin_nf;

  assign sum = {1'b0, lo} + {1'b0, hi};
  assign mid = CNT_W'(sum >> 1);

  always_comb begin
    ptr_n   = ptr;
    lo_n    = lo;
    hi_n    = hi;
    fin     = 1'b0;
    fin_nf  = 1'b0;
    fin_idx = '0;
    case (mode_q)
      MODE_SHIFT, MODE_ACCUM: begin
        if (!res_pass) begin
          fin     = 1'b1;
          fin_idx = ptr;
        end else if (ptr == LAST_C) begin
          fin    = 1'b1;
          fin_nf = 1'b1;
        end else begin
          ptr_n = ptr + ONE_C;
        end
      end
      MODE_HALVE: begin
        if (res_pass) lo_n = mid + ONE_C;
        else          hi_n = mid;
        if (lo_n == hi_n) begin
          fin = 1'b1;
          if (lo_n == NV_C) fin_nf  = 1'b1;
          else              fin_idx = lo_n;
        end
      end
      default: begin
        if (res_pass) begin
          fin = 1'b1;
          if (ptr == '0) fin_nf  = 1'b1;
          else           fin_idx = ptr - ONE_C;
        end else if (ptr == LAST_C) begin
          fin     = 1'b1;
          fin_idx = LAST_C;
        end else begin
          ptr_n = ptr + ONE_C;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      no_fail  <= 1'b0;
      fail_idx <= '0;
      mode_q   <= MODE_SHIFT;
      ptr      <= '0;
      lo       <= '0;
      hi       <= NV_C;
    end else if (start) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      no_fail  <= 1'b0;
      fail_idx <= '0;
      mode_q   <= mode_in;
      ptr      <= '0;
      lo       <= '0;
      hi       <= NV_C;
    end else if (busy && res_valid) begin
      ptr <= ptr_n;
      lo  <= lo_n;
      hi  <= hi_n;
      if (fin) begin
        busy     <= 1'b0;
        done     <= 1'b1;
        no_fail  <= fin_nf;
        fail_idx <= fin_idx;
      end
    end
  end
endmodule

// File: rtl/cyc_stretch_seq.sv
module cyc_stretch_seq
  import cyc_stretch_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int PER_W   = 16,
  localparam int IDX_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int CNT_W  = $clog2(NUM_VEC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode_sel,
  input  logic [PER_W-1:0] slow_period,
  input  logic [PER_W-1:0] fast_period,
  input  logic [IDX_W-1:0] lookup_idx,
  output logic [PER_W-1:0] lookup_period,
  input  logic             res_valid,
  input  logic             res_pass,
  output logic             res_ready,
  output logic             done,
  output logic             no_fail,
  output logic [CNT_W-1:0] fail_idx
);
  seq_mode_e        mode_q;
  logic             busy, fast;
  logic [CNT_W-1:0] ptr, mid;

  cyc_stretch_ctrl #(.NUM_VEC(NUM_VEC), .CNT_W(CNT_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mode_in(seq_mode_e'(mode_sel)),
    .res_valid(res_valid), .res_pass(res_pass),
    .busy(busy), .mode_q(mode_q), .ptr(ptr), .mid(mid),
    .done(done), .no_fail(no_fail), .fail_idx(fail_idx)
  );

  cyc_stretch_fastmap #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .CNT_W(CNT_W)) map_i (
    .mode(mode_q), .busy(busy), .ptr(ptr), .mid(mid),
    .idx(lookup_idx), .fast(fast)
  );

  assign lookup_period = fast ? fast_period : slow_period;
  assign res_ready     = busy;
endmodule

// File: rtl/cyc_stretch_chk.sv
module cyc_stretch_chk #(
  parameter int NUM_VEC = 16,
  parameter int PER_W   = 16,
  parameter int CNT_W   = $clog2(NUM_VEC + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             res_ready,
  input logic             done,
  input logic             no_fail,
  input logic [CNT_W-1:0] fail_idx,
  input logic [PER_W-1:0] lookup_period,
  input logic [PER_W-1:0] slow_period
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !done || start); // R1
  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_ready && !done); // R2
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done && !no_fail |-> fail_idx < CNT_W'(NUM_VEC)); // R7
  AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !res_ready); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(fail_idx) && $stable(no_fail)); // R10
  AST_IDLE_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !res_ready |-> lookup_period == slow_period); // R11
endmodule

bind cyc_stretch_seq cyc_stretch_chk #(.NUM_VEC(NUM_VEC), .PER_W(PER_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .res_ready(res_ready), .done(done),
  .no_fail(no_fail), .fail_idx(fail_idx), .lookup_period(lookup_period),
  .slow_period(slow_period)
);

// File: tb/cyc_stretch_seq_tb.sv
module cyc_stretch_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV    = 16;
  localparam int PW    = 16;
  localparam int IW    = $clog2(NV);
  localparam int CW    = $clog2(NV + 1);
  localparam int SLOWV = 100;
  localparam int FASTV = 60;

  logic clk = 0, rst_n = 0, start = 0, res_valid = 0, res_pass = 0;
  logic [1:0]    mode_sel = 0;
  logic [PW-1:0] slow_period = PW'(SLOWV), fast_period = PW'(FASTV);
  logic [IW-1:0] lookup_idx = 0;
  logic [PW-1:0] lookup_period;
  logic          res_ready, done, no_fail;
  logic [CW-1:0] fail_idx;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_busy = 0, m_done = 0, m_nf = 0, m_idx = 0, m_mode = 0, m_ptr = 0, m_lo = 0, m_hi = NV;

  always #(CLK_PERIOD/2) clk = ~clk;

  cyc_stretch_seq #(.NUM_VEC(NV), .PER_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_sel(mode_sel),
    .slow_period(slow_period), .fast_period(fast_period),
    .lookup_idx(lookup_idx), .lookup_period(lookup_period),
    .res_valid(res_valid), .res_pass(res_pass), .res_ready(res_ready),
    .done(done), .no_fail(no_fail), .fail_idx(fail_idx)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit m_fast(input int i);
    int mid;
    mid = (m_lo + m_hi) / 2;
    if (!m_busy) return 0;
    case (m_mode)
      0: return i == m_ptr;
      1: return i <= m_ptr;
      2: return i <= mid;
      default: return i >= m_ptr;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_nf <= 0; m_idx <= 0; m_ptr <= 0; m_lo <= 0; m_hi <= NV;
    end else if (start) begin
      m_busy <= 1; m_done <= 0; m_nf <= 0; m_idx <= 0; m_mode <= int'(mode_sel);
      m_ptr <= 0; m_lo <= 0; m_hi <= NV;
    end else if (m_busy && res_valid) begin
      int mid, lo, hi;
      bit f, nf;
      int fi;
      mid = (m_lo + m_hi) / 2; lo = m_lo; hi = m_hi; f = 0; nf = 0; fi = 0;
      case (m_mode)
        0, 1: begin
          if (!res_pass) begin f = 1; fi = m_ptr; end
          else if (m_ptr == NV - 1) begin f = 1; nf = 1; end
          else m_ptr <= m_ptr + 1;
        end
        2: begin
          if (res_pass) lo = mid + 1; else hi = mid;
          m_lo <= lo; m_hi <= hi;
          if (lo == hi) begin f = 1; if (lo == NV) nf = 1; else fi = lo; end
        end
        default: begin
          if (res_pass) begin f = 1; if (m_ptr == 0) nf = 1; else fi = m_ptr - 1; end
          else if (m_ptr == NV - 1) begin f = 1; fi = NV - 1; end
          else m_ptr <= m_ptr + 1;
        end
      endcase
      if (f) begin m_busy <= 0; m_done <= 1; m_nf <= int'(nf); m_idx <= fi; end
    end
  end

  // per-clock comparison against the model (R10 handshake and result hold)
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(res_ready == m_busy[0], "R10 res_ready", res_ready, m_busy);
      chk(done == m_done[0], "R10 done", done, m_done);
      if (m_done != 0) begin
        chk(no_fail == m_nf[0], "R10 no_fail", no_fail, m_nf);
        chk(int'(fail_idx) == m_idx, "R10 fail_idx", fail_idx, m_idx);
      end
    end
  end

  function automatic string mode_tag(input int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // one sweep of the pattern; returns 1 when the culprit got the fast period
  task automatic sweep(input int culprit, input string rq, output bit failed);
    failed = 0;
    for (int i = 0; i < NV; i++) begin
      lookup_idx = IW'(i);
      #1;
      chk(int'(lookup_period) == (m_fast(i) ? FASTV : SLOWV), rq, lookup_period,
          m_fast(i) ? FASTV : SLOWV);
      if (i == culprit && int'(lookup_period) == FASTV) failed = 1;
    end
  endtask

  task automatic run_case(input int md, input int culprit, input int exp_runs, input string end_rq);
    int runs = 0;
    bit failed;
    @(negedge clk);
    start = 1; mode_sel = 2'(md);
    @(negedge clk);
    start = 0;
    chk(res_ready == 1'b1 && done == 1'b0, "R2 start opens search", {res_ready, done}, 2);
    while (!done && runs < 4 * NV) begin
      sweep(culprit, mode_tag(md), failed);
      @(negedge clk);
      res_valid = 1; res_pass = !failed;
      @(negedge clk);
      res_valid = 0;
      runs++;
    end
    chk(done == 1'b1, end_rq, done, 1);
    if (culprit < 0) chk(no_fail == 1'b1, end_rq, no_fail, 1);
    else chk(no_fail == 1'b0 && int'(fail_idx) == culprit, end_rq, fail_idx, culprit);
    if (exp_runs > 0) chk(runs == exp_runs, {end_rq, " run count"}, runs, exp_runs);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit dummy;
    repeat (3) @(negedge clk);
    chk(done == 0 && res_ready == 0 && no_fail == 0, "R1 reset state", {done, res_ready, no_fail}, 0);
    rst_n = 1;
    @(negedge clk);
    // R11: idle lookups are slow; R10: verdicts ignored before any start
    res_valid = 1; res_pass = 0;
    sweep(-1, "R11 idle lookup", dummy);
    @(negedge clk);
    res_valid = 0;
    chk(done == 0 && res_ready == 0, "R10 verdict ignored when idle", done, 0);

    run_case(0, 5, 6, "R7 shift fail");
    run_case(0, -1, NV, "R7 shift none");
    run_case(1, 0, 1, "R7 accum first");
    run_case(1, NV - 1, NV, "R7 accum last");
    run_case(2, 7, 0, "R9 halve mid");
    run_case(2, 0, 0, "R9 halve first");
    run_case(2, NV - 1, 0, "R9 halve last");
    run_case(2, -1, 0, "R9 halve none");
    run_case(3, 3, 5, "R8 relax mid");
    run_case(3, -1, 1, "R8 relax none");
    run_case(3, NV - 1, NV, "R8 relax last");

    // R10: held verdicts after completion change nothing
    @(negedge clk);
    res_valid = 1; res_pass = 1;
    repeat (4) @(negedge clk);
    res_valid = 0;
    chk(done == 1 && int'(fail_idx) == NV - 1, "R10 hold after done", fail_idx, NV - 1);
    sweep(-1, "R11 lookup after done", dummy);

    // R2: restart in the middle of a shift search
    @(negedge clk);
    start = 1; mode_sel = 2'd0;
    @(negedge clk);
    start = 0; res_valid = 1; res_pass = 1;
    repeat (3) @(negedge clk);
    res_valid = 0;
    run_case(1, 4, 5, "R2 restart then R7 accum");

    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule